// File: doc/BRIEF.md
# Pipelined Read Host with Outstanding-Read Limit

This block is a read-only master for a memory-mapped bus where requests and responses are decoupled. A client hands it read addresses over a valid/ready stream. The host places each address on the bus and keeps its read strobe high for as long as it has work. It moves on to the next address as soon as the agent takes the current one. It does not wait for data from earlier reads. Data words come back later, one per cycle in which the agent raises its data-valid flag. They always arrive in the order the addresses were taken. The host forwards them to the client as a second stream, one cycle later.

An internal counter tracks how many reads the agent has accepted but not yet answered. It never lets that number exceed `MAX_PENDING`. When the limit is reached, the bus read strobe drops and the client-side ready goes low.

Back-pressure rules:
- The request stream follows the usual valid/ready convention: a transfer happens on a rising edge where both are high, and the client must hold its address while waiting.
- `req_ready` is low whenever the presented bus read is stalled by `m_wait`, and whenever the limit would be reached.
- The response stream has no ready. The client must take every word in the cycle it is offered.

A data-valid pulse from the agent with no read outstanding is a protocol violation. It raises a sticky error flag and the word is discarded.

Top module: `rd_pipe_host`

## Requirements
- R1: While `m_read` and `m_wait` are both high, `m_read` stays high and `m_addr` is unchanged in the following cycle.
- R2: An address accepted on the request stream is shown on `m_addr` with `m_read` high in the very next cycle. Addresses are taken by the agent in the same order the client supplied them.
- R3: With `m_wait` low and room below the limit, a new read is accepted by the agent every cycle without waiting for data. Starting from idle, `MAX_PENDING` reads are accepted in consecutive cycles.
- R4: For each cycle in which `m_rvalid` is high while at least one read is pending, `rsp_valid` is high in the next cycle and `rsp_data` equals that cycle's `m_rdata`. In all other cycles `rsp_valid` is low.
- R5: Response words reach the client in the same order as the addresses were accepted.
- R6: At most `MAX_PENDING` reads are pending at once. With `MAX_PENDING` pending, `m_read` and `req_ready` are both low. An acceptance and a return in the same cycle leave the count unchanged.
- R7: `m_rvalid` high while no read is pending sets `proto_err` at the next edge. That word is not forwarded, and `proto_err` stays high until reset.
- R8: Out of reset, `m_read`, `rsp_valid` and `proto_err` are low and `req_ready` is high.
- R9: While the presented read is stalled (`m_read` and `m_wait` high), `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client offers a read address |
| req_ready | output | 1 | Host takes the offered address this edge |
| req_addr | input | AW | Read address from the client |
| rsp_valid | output | 1 | A returned word is on `rsp_data` |
| rsp_data | output | DW | Returned word, in request order |
| m_addr | output | AW | Bus read address |
| m_read | output | 1 | Bus read strobe |
| m_wait | input | 1 | Agent stalls the presented read |
| m_rdata | input | DW | Read data from the agent |
| m_rvalid | input | 1 | `m_rdata` carries a returned word |
| proto_err | output | 1 | Sticky flag: data returned with nothing pending |

## Verification
If the pending count runs high, `req_ready` and `m_read` freeze low early. The bus then shows fewer consecutive accepts than the limit allows, and the stream can stall for good. If the count runs low, a return is taken as unsolicited: `proto_err` rises and the next `rsp_valid` is missing one cycle after the agent's data-valid. A broken issue register shows up on the bus in the cycle after the fault, as a changed address during a stall or a dropped or duplicated address. Each of these is visible at the ports within a cycle of its cause, so a reference model compared every cycle catches it at once.

// File: rtl/rdh_pkg.sv
package rdh_pkg;

  typedef enum logic [1:0] {
    CNT_KEEP = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/rdh_issue.sv
module rdh_issue #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          m_wait,
  output logic          m_read,
  output logic [AW-1:0] m_addr,
  output logic          slot_free,
  output logic          bus_acc
);

  // the presented read leaves the slot at an edge where the agent is not stalling
  assign bus_acc   = m_read && !m_wait;
  assign slot_free = !m_read || !m_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_read <= 1'b0;
      m_addr <= '0;
    end else if (load) begin
      m_read <= 1'b1;
      m_addr <= load_addr;
    end else if (bus_acc) begin
      m_read <= 1'b0;
    end
  end

endmodule

// File: rtl/rdh_credit.sv
module rdh_credit
  import rdh_pkg::*;
#(
  parameter int MAXP = 4,
  localparam int CW = $clog2(MAXP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_acc,
  input  logic          rvalid,
  output logic [CW-1:0] pend_cnt,
  output logic          has_room,
  output logic          ret_ok,
  output logic          err
);

  localparam logic [CW:0] LIMIT = (CW + 1)'(MAXP);

  cnt_op_e     op;
  logic [CW:0] after_issue;

  assign ret_ok      = rvalid && (pend_cnt != '0);
  // count as it will stand once this cycle's accept lands; a return does not free room early
  assign after_issue = {1'b0, pend_cnt} + (CW + 1)'(bus_acc);
  assign has_room    = after_issue < LIMIT;

  always_comb begin
    op = CNT_KEEP;
    if (bus_acc && !ret_ok) op = CNT_INC;
    else if (ret_ok && !bus_acc) op = CNT_DEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
    end else begin
      unique case (op)
        CNT_INC:  pend_cnt <= pend_cnt + 1'b1;
        CNT_DEC:  pend_cnt <= pend_cnt - 1'b1;
        default:  pend_cnt <= pend_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else if (rvalid && (pend_cnt == '0)) err <= 1'b1;
  end

endmodule

// File: rtl/rdh_return.sv
module rdh_return #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rsp_data <= '0;
    else if (take) rsp_data <= rdata;
  end

endmodule

// File: rtl/rd_pipe_host.sv
module rd_pipe_host #(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int MAX_PENDING = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] m_addr,
  output logic          m_read,
  input  logic          m_wait,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_rvalid,
  output logic          proto_err
);

  localparam int CW = $clog2(MAX_PENDING + 1);

  logic          slot_free;
  logic          bus_acc;
  logic          has_room;
  logic          ret_ok;
  logic          load;
  logic [CW-1:0] pend_cnt;

  assign req_ready = slot_free && has_room;
  assign load      = req_valid && req_ready;

  rdh_issue #(.AW(AW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (req_addr),
    .m_wait    (m_wait),
    .m_read    (m_read),
    .m_addr    (m_addr),
    .slot_free (slot_free),
    .bus_acc   (bus_acc)
  );

  rdh_credit #(.MAXP(MAX_PENDING)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_acc  (bus_acc),
    .rvalid   (m_rvalid),
    .pend_cnt (pend_cnt),
    .has_room (has_room),
    .ret_ok   (ret_ok),
    .err      (proto_err)
  );

  rdh_return #(.DW(DW)) u_return (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ret_ok),
    .rdata     (m_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/rdh_chk.sv
module rdh_chk #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int MAXP = 4,
  localparam int CW  = $clog2(MAXP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] m_addr,
  input logic          m_read,
  input logic          m_wait,
  input logic [DW-1:0] m_rdata,
  input logic          m_rvalid,
  input logic          proto_err,
  input logic [CW-1:0] pend_cnt
);

  localparam logic [CW-1:0] FULL = CW'(MAXP);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_read && m_wait |=> m_read && $stable(m_addr)); // R1

  AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> m_read && (m_addr == $past(req_addr))); // R2

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid && (pend_cnt != '0) |=> rsp_valid && (rsp_data == $past(m_rdata))); // R4

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rvalid |=> !rsp_valid); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == FULL) |-> !m_read && !req_ready); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= FULL); // R6

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid && (pend_cnt == '0) |=> proto_err && !rsp_valid); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    m_read && m_wait |-> !req_ready); // R9

endmodule

bind rd_pipe_host rdh_chk #(.AW(AW), .DW(DW), .MAXP(MAX_PENDING)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .m_addr    (m_addr),
  .m_read    (m_read),
  .m_wait    (m_wait),
  .m_rdata   (m_rdata),
  .m_rvalid  (m_rvalid),
  .proto_err (proto_err),
  .pend_cnt  (pend_cnt)
);

// File: tb/rd_pipe_host_tb_top.sv
module rd_pipe_host_tb_top;

  localparam int AW      = 16;
  localparam int DW      = 32;
  localparam int MAXP    = 4;
  localparam int CLK_PER = 10;
  localparam int WD_LIM  = 50000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] m_addr;
  logic          m_read;
  logic          m_wait;
  logic [DW-1:0] m_rdata;
  logic          m_rvalid;
  logic          proto_err;

  always #(CLK_PER / 2) clk = ~clk;

  rd_pipe_host #(.AW(AW), .DW(DW), .MAX_PENDING(MAXP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .m_addr    (m_addr),
    .m_read    (m_read),
    .m_wait    (m_wait),
    .m_rdata   (m_rdata),
    .m_rvalid  (m_rvalid),
    .proto_err (proto_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int cycle = 0;
  int wd = 0;

  logic [15:0]   lf = 16'hACE1;
  int            mode = 0;
  bit            hold_resp = 0;
  bit            wait_en = 0;
  bit            spur = 0;
  int            req_budget = 0;
  bit            hv = 0;
  logic [AW-1:0] ha = '0;
  logic [AW-1:0] next_addr = 16'h0100;

  logic [AW-1:0] issue_q[$];
  logic [AW-1:0] order_q[$];
  logic [AW-1:0] agent_a[$];
  int            agent_t[$];
  int            last_t = 0;

  int            model_pend = 0;
  bit            exp_v = 0;
  logic [DW-1:0] exp_d = '0;
  bit            exp_err = 0;
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr = '0;
  bit            last_hacc = 0;
  logic [AW-1:0] last_hacc_addr = '0;
  int            bus_acc_cnt = 0;
  int            first_acc = 0;
  int            last_acc = 0;

  function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=0x%0h expected=0x%0h", tag, cycle, act, expv);
    end
  endtask

  task automatic step();
    bit   hacc;
    bit   bacc;
    bit   rv;
    int   lat;
    @(negedge clk);
    cycle++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    // registered outputs against the model's prediction from last cycle
    chk(rsp_valid == exp_v, "R4 rsp_valid", DW'(rsp_valid), DW'(exp_v));
    if (exp_v) chk(rsp_data == exp_d, "R5 rsp_data order", rsp_data, exp_d);
    chk(proto_err == exp_err, "R7 proto_err", DW'(proto_err), DW'(exp_err));
    // drive this cycle's inputs
    if (!hv && req_budget > 0 && (mode == 0 || lf[3:0] < 4'd12)) begin
      hv = 1;
      ha = next_addr;
      next_addr = next_addr + 16'd7;
      req_budget--;
    end
    req_valid = hv;
    req_addr  = ha;
    m_wait    = wait_en && (lf[6:4] < 3'd3);
    if (spur) begin
      m_rvalid = 1'b1;
      m_rdata  = 32'hBAD0_0BAD;
    end else if (!hold_resp && agent_t.size() > 0 && agent_t[0] <= cycle) begin
      m_rvalid = 1'b1;
      m_rdata  = fdat(agent_a[0]);
      void'(agent_a.pop_front());
      void'(agent_t.pop_front());
    end else begin
      m_rvalid = 1'b0;
      m_rdata  = 32'hDEAD_BEEF;
    end
    #1;
    if (prev_stall) chk(m_read && m_addr == prev_addr, "R1 hold", DW'(m_addr), DW'(prev_addr));
    if (last_hacc) chk(m_read && m_addr == last_hacc_addr, "R2 issue next",
                       DW'(m_addr), DW'(last_hacc_addr));
    if (model_pend == MAXP) chk(!m_read && !req_ready, "R6 limit",
                                DW'({m_read, req_ready}), 0);
    if (m_read && m_wait) chk(!req_ready, "R9 stall backpressure", DW'(req_ready), 0);
    hacc = req_valid && req_ready;
    bacc = m_read && !m_wait;
    rv   = m_rvalid;
    lat  = (mode == 0) ? 1 : 1 + int'(lf[10:8]) % 5;
    if (bacc) begin
      chk(issue_q.size() > 0 && m_addr == issue_q[0], "R2 bus order", DW'(m_addr),
          issue_q.size() > 0 ? DW'(issue_q[0]) : 0);
      if (issue_q.size() > 0) void'(issue_q.pop_front());
      last_t = (cycle + lat > last_t) ? cycle + lat : last_t;
      agent_a.push_back(m_addr);
      agent_t.push_back(last_t);
      if (bus_acc_cnt == 0) first_acc = cycle;
      last_acc = cycle;
      bus_acc_cnt++;
    end
    if (hacc) begin
      issue_q.push_back(req_addr);
      order_q.push_back(req_addr);
      hv = 0;
    end
    last_hacc      = hacc;
    last_hacc_addr = req_addr;
    prev_stall     = m_read && m_wait;
    prev_addr      = m_addr;
    exp_v = 0;
    if (rv) begin
      if (model_pend > 0) begin
        exp_v = 1;
        exp_d = fdat(order_q.pop_front());
        model_pend--;
      end else begin
        exp_err = 1;
      end
    end
    if (bacc) model_pend++;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIM && !finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog cycle %0d actual=running expected=done", cycle);
      summary();
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    m_wait    = 1'b0;
    m_rdata   = '0;
    m_rvalid  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: idle state after reset
    chk(!m_read, "R8 m_read", DW'(m_read), 0);
    chk(!rsp_valid, "R8 rsp_valid", DW'(rsp_valid), 0);
    chk(!proto_err, "R8 proto_err", DW'(proto_err), 0);
    chk(req_ready, "R8 req_ready", DW'(req_ready), 1);

    // fill to the limit with returns held back (R3, R6)
    mode = 0; wait_en = 0; hold_resp = 1; req_budget = MAXP + 1;
    for (int i = 0; i < 40 && bus_acc_cnt < MAXP; i++) step();
    chk(bus_acc_cnt == MAXP, "R3 fill count", DW'(bus_acc_cnt), DW'(MAXP));
    chk(last_acc - first_acc == MAXP - 1, "R3 back-to-back", DW'(last_acc - first_acc),
        DW'(MAXP - 1));
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!m_read && !req_ready, "R6 blocked at limit", DW'({m_read, req_ready}), 0);
    end
    chk(bus_acc_cnt == MAXP, "R6 no extra issue", DW'(bus_acc_cnt), DW'(MAXP));

    // mixed traffic: random stalls and latencies, overlapping accept and return
    hold_resp = 0; mode = 1; wait_en = 1; req_budget = 400;
    for (int i = 0; i < 20000; i++) begin
      if (req_budget == 0 && !hv && order_q.size() == 0 && model_pend == 0) break;
      step();
    end
    chk(order_q.size() == 0, "R5 all returned", DW'(order_q.size()), 0);
    chk(bus_acc_cnt == MAXP + 1 + 400, "R2 all issued", DW'(bus_acc_cnt), DW'(MAXP + 401));

    // unsolicited data with nothing pending (R7)
    wait_en = 0;
    repeat (3) step();
    chk(!proto_err, "R7 clear before", DW'(proto_err), 0);
    spur = 1;
    step();
    spur = 0;
    step();
    chk(proto_err, "R7 raised", DW'(proto_err), 1);
    chk(!rsp_valid, "R7 word dropped", DW'(rsp_valid), 0);
    repeat (3) step();
    chk(proto_err, "R7 sticky", DW'(proto_err), 1);
    summary();
  end

endmodule